// File: doc/BRIEF.md
# Reflected CRC-32 / CRC-32C Accumulate Unit

This unit is an execution-stage datapath that advances a running CRC over one register-sized operand. Each request supplies a 32-bit accumulator, a data operand of 8, 16 or 32 bits and a width code. A select bit picks between two generator polynomials: the Castagnoli polynomial 0x1EDC6F41 and the classic Ethernet polynomial 0x04C11DB7. The unit returns the updated 32-bit accumulator. All bit orders follow the reflected (least significant bit first) convention, so chained results agree with common table-driven software CRC routines.

The unit applies no seed inversion and no final complement. The caller seeds the accumulator, for example with all ones, and complements the final value itself. A request is presented with a one-cycle `start` strobe. The result and a `done` strobe appear exactly one clock later, whatever the operand values or width. A new request may be issued on every cycle. The reserved width code is answered with an `unsupported` flag and leaves the accumulator unchanged.

Top module: `crc_acc_unit`

## Requirements
- R1: While `rstN` is low at a rising edge, the unit clears `done`, `unsupported` and `result` to zero on that edge.
- R2: `done` is high in the cycle after each cycle with `start` high, and is low after every cycle with `start` low. The latency is one clock for every width code and every operand value.
- R3: `polySel`=1 selects the polynomial 0x1EDC6F41 and `polySel`=0 selects 0x04C11DB7. The result equals the bit-reverse of the remainder of (reverse(acc)·x^n XOR reverse(data[n-1:0])·x^32) divided by the selected polynomial, where n is the operand width.
- R4: `sizeCode` selects the operand width n = 8 << sizeCode: code 0 gives 8 bits, 1 gives 16 bits and 2 gives 32 bits.
- R5: Bits of `dataIn` at positions n and above have no effect on `result`.
- R6: `sizeCode`=3 is reserved. The cycle after such a start has `done`=1, `unsupported`=1 and `result` equal to the `accIn` that was presented. `unsupported` is never high without `done`.
- R7: No inversion is applied inside the unit, so an accumulator of 0 and data of 0 give a result of 0 for every valid width.
- R8: Starts on consecutive cycles each yield their own correct result one cycle later, giving one operation per cycle.
- R9: `result` keeps its value in any cycle that follows a cycle with `start` low.
- R10: Seeding with 0xFFFFFFFF and complementing the final value, the ASCII string "123456789" gives 0xE3069283 with `polySel`=1 and 0xCBF43926 with `polySel`=0. The same values are obtained when the string is fed as bytes, as halfwords (little-endian byte packing) or as words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe; operands are sampled on this cycle's rising edge |
| accIn | input | 32 | Incoming CRC accumulator |
| dataIn | input | 32 | Data operand; only the low n bits are used |
| sizeCode | input | 2 | Operand width code (0: 8, 1: 16, 2: 32 bits, 3: reserved) |
| polySel | input | 1 | 1 selects 0x1EDC6F41, 0 selects 0x04C11DB7 |
| done | output | 1 | High for one cycle when `result` holds a new value |
| result | output | 32 | Updated CRC accumulator |
| unsupported | output | 1 | High with `done` when the request used the reserved width code |

## Verification
The unit is driven with random accumulators and data under every width code and both polynomials. A bench model built directly on the shift-and-divide definition catches any wrong polynomial, width or bit order. The check-string runs fed as bytes, halfwords and words tell a width-dependent error apart from a polynomial error. They also expose any hidden inversion, because only the caller-side complement may produce the known check values. Pairs of operands that differ only above the selected width show that those bits are masked. Back-to-back bursts, idle gaps and reserved-code requests separate the one-cycle latency, the hold behaviour and the no-op pass-through.

// File: rtl/crc_acc_pkg.sv
package crc_acc_pkg;
  localparam int ACC_W     = 32;
  localparam int SIZE_W    = 2;
  localparam int NUM_SIZES = 3;
  localparam logic [ACC_W-1:0] POLY_IEEE       = 32'h04C11DB7;
  localparam logic [ACC_W-1:0] POLY_CASTAGNOLI = 32'h1EDC6F41;

  typedef struct packed {
    logic loadCrc;   // capture computed remainder
    logic loadAcc;   // capture accumulator unchanged (reserved width)
  } ctrlStrobes_t;
endpackage

// File: rtl/crc_acc_ctrl.sv
module crc_acc_ctrl
  import crc_acc_pkg::*;
#(
  parameter int SW = SIZE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [SW-1:0] sizeCode,
  output ctrlStrobes_t  strobes,
  output logic          done,
  output logic          unsupported
);
  localparam logic [SW-1:0] RESERVED_CODE = SW'(NUM_SIZES);

  logic sizeBad;
  assign sizeBad = (sizeCode == RESERVED_CODE);

  always_comb begin
    strobes.loadCrc = start && !sizeBad;
    strobes.loadAcc = start && sizeBad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done        <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      done        <= start;
      unsupported <= start && sizeBad;
    end
  end
endmodule

// File: rtl/crc_acc_dp.sv
module crc_acc_dp
  import crc_acc_pkg::*;
#(
  parameter int AW = ACC_W,
  parameter int SW = SIZE_W,
  parameter logic [AW-1:0] POLY_A = POLY_IEEE,
  parameter logic [AW-1:0] POLY_B = POLY_CASTAGNOLI
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic [AW-1:0] accIn,
  input  logic [AW-1:0] dataIn,
  input  logic [SW-1:0] sizeCode,
  input  logic          polySel,
  output logic [AW-1:0] result
);
  function automatic logic [AW-1:0] reflect(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  localparam logic [AW-1:0] REFL_A = reflect(POLY_A);
  localparam logic [AW-1:0] REFL_B = reflect(POLY_B);

  logic [AW-1:0] polyRefl;
  logic [AW-1:0] stepOut [NUM_SIZES];
  logic [AW-1:0] crcNext;

  assign polyRefl = polySel ? REFL_B : REFL_A;

  // One unrolled LSB-first divider per operand width
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
    localparam int W = 8 << g;
    localparam logic [AW-1:0] MASK = {AW{1'b1}} >> (AW - W);
    always_comb begin
      logic [AW-1:0] c;
      c = accIn ^ (dataIn & MASK);
      for (int i = 0; i < W; i++) begin
        c = c[0] ? ((c >> 1) ^ polyRefl) : (c >> 1);
      end
      stepOut[g] = c;
    end
  end

  always_comb begin
    case (sizeCode)
      2'd0:    crcNext = stepOut[0];
      2'd1:    crcNext = stepOut[1];
      default: crcNext = stepOut[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                result <= '0;
    else if (strobes.loadCrc) result <= crcNext;
    else if (strobes.loadAcc) result <= accIn;
  end
endmodule

// File: rtl/crc_acc_unit.sv
module crc_acc_unit
  import crc_acc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] accIn,
  input  logic [31:0] dataIn,
  input  logic [1:0]  sizeCode,
  input  logic        polySel,
  output logic        done,
  output logic [31:0] result,
  output logic        unsupported
);
  ctrlStrobes_t strobes;

  crc_acc_ctrl #(.SW(SIZE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .sizeCode(sizeCode),
    .strobes(strobes), .done(done), .unsupported(unsupported)
  );

  crc_acc_dp #(.AW(ACC_W), .SW(SIZE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accIn(accIn),
    .dataIn(dataIn), .sizeCode(sizeCode), .polySel(polySel),
    .result(result)
  );
endmodule

// File: rtl/crc_acc_chk.sv
module crc_acc_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [31:0] accIn,
  input logic [31:0] dataIn,
  input logic [1:0]  sizeCode,
  input logic        polySel,
  input logic        done,
  input logic [31:0] result,
  input logic        unsupported
);
  p_reset_clears_r1: assert property (@(posedge clk)
    !rstN |=> (!done && !unsupported && result == 32'd0));

  p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  p_no_done_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

  p_reserved_passthru_r6: assert property (@(posedge clk) disable iff (!rstN)
    (start && sizeCode == 2'd3) |=> (unsupported && result == $past(accIn)));

  p_unsup_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    unsupported |-> done);

  p_zero_in_zero_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && accIn == 32'd0 && dataIn == 32'd0 && sizeCode != 2'd3)
      |=> (result == 32'd0 && !unsupported));

  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(result));
endmodule

bind crc_acc_unit crc_acc_chk chk_i (.*);

// File: tb/crc_acc_unit_tb_top.sv
`timescale 1ns/1ps
module crc_acc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] accIn = '0;
  logic [31:0] dataIn = '0;
  logic [1:0]  sizeCode = '0;
  logic        polySel = 1'b0;
  logic        done;
  logic [31:0] result;
  logic        unsupported;

  int nChecks = 0;
  int nFail   = 0;
  bit modelOn = 1'b0;

  logic        expDone = 1'b0;
  logic        expUnsup = 1'b0;
  logic [31:0] expResult = '0;

  always #5 clk = ~clk;

  crc_acc_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .accIn(accIn), .dataIn(dataIn),
    .sizeCode(sizeCode), .polySel(polySel), .done(done), .result(result),
    .unsupported(unsupported)
  );

  // Definition-level reference: MSB-first long division of reflected operands
  function automatic logic [31:0] refCrc(input logic [31:0] acc, input logic [31:0] data,
                                         input int bits, input bit castagnoli);
    logic [63:0] x;
    logic [32:0] poly;
    logic [31:0] ra, rd, rem, out;
    poly = castagnoli ? 33'h11EDC6F41 : 33'h104C11DB7;
    rd = '0;
    for (int i = 0; i < 32; i++) ra[i] = acc[31-i];
    for (int i = 0; i < bits; i++) rd[i] = data[bits-1-i];
    x = ({32'd0, ra} << bits) ^ ({32'd0, rd} << 32);
    for (int i = 63; i >= 32; i--)
      if (x[i]) x = x ^ ({31'd0, poly} << (i - 32));
    rem = x[31:0];
    for (int i = 0; i < 32; i++) out[i] = rem[31-i];
    return out;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Cycle model, updated on each rising edge from the bench's own inputs
  always @(posedge clk) begin
    if (!rstN) begin
      expDone <= 1'b0; expUnsup <= 1'b0; expResult <= '0;
    end else if (start) begin
      expDone  <= 1'b1;
      expUnsup <= (sizeCode == 2'd3);
      expResult <= (sizeCode == 2'd3) ? accIn
                 : refCrc(accIn, dataIn, 8 << sizeCode, polySel);
    end else begin
      expDone <= 1'b0; expUnsup <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      check(done === expDone, "R2 done strobe", {31'd0, done}, {31'd0, expDone});
      check(unsupported === expUnsup, "R6 unsupported flag",
            {31'd0, unsupported}, {31'd0, expUnsup});
      check(result === expResult, "R3/R4/R9 result vs model", result, expResult);
    end
  end

  task automatic runOp(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                       input bit sel, output logic [31:0] res);
    @(negedge clk);
    accIn = a; dataIn = d; sizeCode = sz; polySel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    res = result;
  endtask

  byte unsigned msg [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

  task automatic golden(input bit sel, input logic [31:0] want);
    logic [31:0] a;
    // bytes
    a = 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++) runOp(a, {24'd0, msg[i]}, 2'd0, sel, a);
    check(~a === want, "R10 check string as bytes", ~a, want);
    // halfwords then final byte
    a = 32'hFFFFFFFF;
    for (int i = 0; i < 8; i += 2) runOp(a, {16'd0, msg[i+1], msg[i]}, 2'd1, sel, a);
    runOp(a, {24'd0, msg[8]}, 2'd0, sel, a);
    check(~a === want, "R10 check string as halfwords", ~a, want);
    // words then final byte
    a = 32'hFFFFFFFF;
    for (int i = 0; i < 8; i += 4)
      runOp(a, {msg[i+3], msg[i+2], msg[i+1], msg[i]}, 2'd2, sel, a);
    runOp(a, {24'd0, msg[8]}, 2'd0, sel, a);
    check(~a === want, "R10 check string as words", ~a, want);
  endtask

  initial begin
    logic [31:0] r1, r2, held;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && unsupported === 1'b0, "R1 reset flags",
          {30'd0, done, unsupported}, 32'd0);
    check(result === 32'd0, "R1 reset result", result, 32'd0);
    rstN = 1'b1;
    modelOn = 1'b1;

    // R7: zero in gives zero out, every width and polynomial
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < 2; p++) begin
        runOp(32'd0, 32'd0, 2'(s), p[0], r1);
        check(r1 === 32'd0, "R7 no internal inversion", r1, 32'd0);
      end

    // R3/R4: random operands, all widths, both polynomials
    for (int k = 0; k < 60; k++) begin
      logic [31:0] a, d;
      a = $urandom; d = $urandom;
      runOp(a, d, 2'(k % 3), k[2], r1);
      check(r1 === refCrc(a, d, 8 << (k % 3), k[2]), "R3/R4 random operand",
            r1, refCrc(a, d, 8 << (k % 3), k[2]));
    end

    // R5: upper data bits ignored
    runOp(32'h12345678, 32'h000000A5, 2'd0, 1'b1, r1);
    runOp(32'h12345678, 32'hFFFF5AA5, 2'd0, 1'b1, r2);
    check(r1 === r2, "R5 byte operand upper bits", r2, r1);
    runOp(32'hCAFEF00D, 32'h0000BEEF, 2'd1, 1'b0, r1);
    runOp(32'hCAFEF00D, 32'h1234BEEF, 2'd1, 1'b0, r2);
    check(r1 === r2, "R5 halfword operand upper bits", r2, r1);

    // R6: reserved width passes accumulator through
    runOp(32'hDEADBEEF, 32'h55555555, 2'd3, 1'b1, r1);
    check(r1 === 32'hDEADBEEF, "R6 reserved code no-op", r1, 32'hDEADBEEF);
    check(unsupported === 1'b1 && done === 1'b1, "R6 flag with done",
          {30'd0, unsupported, done}, 32'd3);

    // R9: result holds across idle cycles
    runOp(32'h0F0F0F0F, 32'h33, 2'd0, 1'b0, held);
    repeat (4) @(negedge clk);
    check(result === held && done === 1'b0, "R9 hold while idle", result, held);

    // R8: back-to-back burst, checked cycle by cycle by the model
    @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      accIn = $urandom; dataIn = $urandom; sizeCode = 2'($urandom % 4);
      polySel = $urandom % 2; start = 1'b1;
      @(negedge clk);
      check(done === 1'b1, "R8 full-throughput done", {31'd0, done}, 32'd1);
    end
    start = 1'b0;

    // R10: known check values
    golden(1'b1, 32'hE3069283);
    golden(1'b0, 32'hCBF43926);

    // R1: reset mid-stream clears outputs
    @(negedge clk);
    start = 1'b1; sizeCode = 2'd3; accIn = 32'hA5A5A5A5; rstN = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b0 && unsupported === 1'b0 && result === 32'd0,
          "R1 reset overrides start", result, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    modelOn = 1'b0;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(20000 * 10);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule